// File: doc/BRIEF.md
# Bus Master Error Status and Lockout Register

This block keeps the sticky error record of a DMA bus master. The transfer sequencer reports at most one failure per clock on a one-hot event input. There are five causes: the target aborted, no target responded, read data failed its parity check, the master was used while disabled, and the DMA engine and the master lost step with each other. Each event latches a flag for its cause, a common error flag, and one bit of a five-bit system status field. The common flag drives a level interrupt. While any cause flag is held, a halt output tells the command logic to take no new work.

Software reads the flags through a read-back port and clears them by writing ones through a write-data and write-enable port. A write of one to a cause flag also clears its system status bit and lifts that cause's share of the halt. A write of one to the common flag withdraws the interrupt. The active-low hardware reset clears everything at once.

Top module: `mes_ctrl`

## Requirements
- R1: A target-abort event (event bit 0) sets cause flag 0 (read-back bit 0), the common flag (read-back bit 5) and system status bit 4.
- R2: A master-abort event (event bit 1) sets cause flag 1 (read-back bit 1), the common flag and system status bit 3.
- R3: A read-parity event (event bit 2) sets cause flag 2 (read-back bit 2), the common flag and system status bit 2.
- R4: An interface-disabled event (event bit 3) sets cause flag 3 (read-back bit 3), the common flag and system status bit 1.
- R5: An internal-failure event (event bit 4) sets cause flag 4 (read-back bit 4), the common flag and system status bit 0.
- R6: A flag stays set until it is cleared. A write with write-data bit i at 1 (i in 0..4) clears cause flag i and its system status bit in the next cycle. A zero in any write-data bit leaves that bit unchanged.
- R7: The interrupt output equals the common flag. A write with write-data bit 5 at 1 clears the common flag, which drops the interrupt, and leaves the cause flags as they are.
- R8: The halt output is high exactly while at least one cause flag is set. It stays high until the last set cause flag is cleared, even if the common flag has already been cleared.
- R9: When an event and a clearing write hit the same bit in the same clock, the bit ends up set.
- R10: Driving the active-low reset low clears all flags, the system status field, the interrupt and the halt at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| err_evt | input | 5 | One-hot error events from the transfer sequencer |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Write data; a 1 clears the bit at that position |
| rd_data | output | 6 | Read-back: cause flags in bits 4..0, common flag in bit 5 |
| sys_stat | output | 5 | System status field, one bit per cause |
| irq | output | 1 | Level bus-error interrupt |
| halt | output | 1 | Blocks new commands while any cause is latched |

## Verification
The bench uses the default parameters: five causes and a two-stage reset synchroniser. With these values every cause-to-status position, including the reversed mapping at both ends of the field, can be checked against a fixed expectation. The two-stage release also fixes the number of idle cycles the bench waits after reset before it resumes. The bench clears flags one at a time and in mixed orders, applies collisions between events and clears, and applies a hardware reset in the middle of a clock period while flags are set.

// File: rtl/mes_pkg.sv
package mes_pkg;
  localparam int unsigned MES_NUM_CAUSE   = 5;
  localparam int unsigned MES_SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    CAUSE_TGT_ABORT  = 3'd0,
    CAUSE_NO_TARGET  = 3'd1,
    CAUSE_RD_PARITY  = 3'd2,
    CAUSE_DISABLED   = 3'd3,
    CAUSE_SYNC_FAIL  = 3'd4
  } mes_cause_e;
endpackage

// File: rtl/mes_rst_sync.sv
module mes_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/mes_sticky_bit.sv
module mes_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;          // set dominates any clear in the same cycle
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/mes_ctrl.sv
module mes_ctrl #(
  parameter int unsigned N_CAUSE     = mes_pkg::MES_NUM_CAUSE,
  parameter int unsigned SYNC_STAGES = mes_pkg::MES_SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] err_evt,
  input  logic               wr_en,
  input  logic [N_CAUSE:0]   wr_data,
  output logic [N_CAUSE:0]   rd_data,
  output logic [N_CAUSE-1:0] sys_stat,
  output logic               irq,
  output logic               halt
);
  localparam int unsigned SUM_BIT = N_CAUSE;

  logic               rst_core_n;
  logic [N_CAUSE-1:0] cause_q;
  logic [N_CAUSE-1:0] sys_q;
  logic               sum_q;
  logic [N_CAUSE:0]   clr_vec;
  logic               any_evt;

  mes_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  always_comb begin
    clr_vec = wr_en ? wr_data : '0;
    any_evt = |err_evt;
  end

  for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
    mes_sticky_bit u_flag (
      .clk   (clk),
      .rst_n (rst_core_n),
      .set_i (err_evt[i]),
      .clr_i (clr_vec[i]),
      .q_o   (cause_q[i])
    );
    // status field is ordered opposite to the cause index
    mes_sticky_bit u_sys (
      .clk   (clk),
      .rst_n (rst_core_n),
      .set_i (err_evt[i]),
      .clr_i (clr_vec[i]),
      .q_o   (sys_q[N_CAUSE-1-i])
    );

    assert_sys_mirror_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
      sys_q[N_CAUSE-1-i] == cause_q[i]);
  end

  mes_sticky_bit u_sum (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set_i (any_evt),
    .clr_i (clr_vec[SUM_BIT]),
    .q_o   (sum_q)
  );

  assign rd_data  = {sum_q, cause_q};
  assign sys_stat = sys_q;
  assign irq      = sum_q;
  assign halt     = |cause_q;

  assert_evt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(err_evt));
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(irq) |-> $past(any_evt));
  assert_halt_source_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(halt) |-> $past(any_evt));
  assert_halt_implies_sum_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (any_evt && !halt) |=> (halt && irq));
endmodule

// File: tb/sim_mes_ctrl.sv
module sim_mes_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NC = 5;

  typedef struct {
    logic [NC:0]   rd;
    logic [NC-1:0] sys;
    logic          irq;
    logic          halt;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] err_evt;
  logic          wr_en;
  logic [NC:0]   wr_data;
  logic [NC:0]   rd_data;
  logic [NC-1:0] sys_stat;
  logic          irq;
  logic          halt;

  exp_t          sb_q[$];
  int            n_cmp = 0;
  int            n_bad = 0;
  logic [NC-1:0] m_cause;
  logic          m_sum;

  always #(CLK_PERIOD/2) clk = ~clk;

  mes_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sys_stat(sys_stat),
    .irq(irq), .halt(halt)
  );

  function automatic logic [NC-1:0] rev(input logic [NC-1:0] v);
    logic [NC-1:0] r;
    for (int k = 0; k < NC; k++) r[NC-1-k] = v[k];
    return r;
  endfunction

  // driver: apply one cycle of stimulus and queue the state expected after it
  task automatic step(input logic [NC-1:0] ev, input logic we,
                      input logic [NC:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    err_evt = ev; wr_en = we; wr_data = wd;
    for (int k = 0; k < NC; k++)
      if (ev[k]) m_cause[k] = 1'b1;
      else if (we && wd[k]) m_cause[k] = 1'b0;
    if (ev != 0) m_sum = 1'b1;
    else if (we && wd[NC]) m_sum = 1'b0;
    e.rd = {m_sum, m_cause}; e.sys = rev(m_cause);
    e.irq = m_sum; e.halt = |m_cause; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step('0, 1'b0, '0, tag);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (rd_data !== e.rd || sys_stat !== e.sys || irq !== e.irq || halt !== e.halt) begin
        n_bad++;
        $display("FAIL %s: rd=%b sys=%b irq=%b halt=%b expected rd=%b sys=%b irq=%b halt=%b",
                 e.tag, rd_data, sys_stat, irq, halt, e.rd, e.sys, e.irq, e.halt);
      end
    end
  end

  task automatic cause_cycle(input int idx, input string tag);
    step(NC'(1) << idx, 1'b0, '0, tag);
    idle(tag);
    step('0, 1'b1, '0, "R6 zero write");
    step('0, 1'b1, (NC+1)'(1) << idx, "R6 clear cause");
    step('0, 1'b1, 6'h20, "R7 clear common");
  endtask

  task automatic drain();
    @(posedge clk); #2;
  endtask

  task automatic boot();
    rst_n = 1'b0; err_evt = '0; wr_en = 1'b0; wr_data = '0;
    m_cause = '0; m_sum = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    boot();
    idle("R10 reset state");

    cause_cycle(0, "R1");
    cause_cycle(1, "R2");
    cause_cycle(2, "R3");
    cause_cycle(3, "R4");
    cause_cycle(4, "R5");

    // two causes latched, staged clearing
    step(5'b00010, 1'b0, '0, "R2");
    step(5'b10000, 1'b0, '0, "R5");
    step('0, 1'b1, 6'h20, "R7 common cleared, halt held");
    step('0, 1'b1, 6'h02, "R8 one cause left");
    idle("R8 still halted");
    step('0, 1'b1, 6'h10, "R8 halt released");

    // event and clear collide on the same bits
    step(5'b00100, 1'b1, 6'h24, "R9 set wins");
    idle("R9 held");
    step(5'b01000, 1'b1, 6'h28, "R9 set wins second");
    step('0, 1'b1, 6'h3F, "R6 clear all");

    // hardware reset in mid period while flags are held
    step(5'b00001, 1'b0, '0, "R1");
    step(5'b10000, 1'b0, '0, "R5");
    drain();
    @(negedge clk); #2;
    err_evt = '0; wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    n_cmp++;
    if (rd_data !== '0 || sys_stat !== '0 || irq !== 1'b0 || halt !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 async: rd=%b sys=%b irq=%b halt=%b expected all zero",
               rd_data, sys_stat, irq, halt);
    end
    boot();
    idle("R10 after reset");
    step(5'b01000, 1'b0, '0, "R4 after reset");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule